// File: doc/BRIEF.md
# Four-Lane 7:1 Display Link Serializer

This block is the digital core of a flat-panel display link transmitter. It accepts a 28-bit parallel pixel word once per pixel period. The word carries the colour bits along with horizontal sync, vertical sync and data enable. The block spreads the word over four serial data lanes that each send seven bits per pixel period. It also produces a fifth lane that carries a framing clock. Every lane output is a single-ended bit that stands for one differential pair. Analog drivers, output swing and the PLL that makes the bit clock are outside this block.

All logic runs on a bit clock at seven times the pixel rate. The pixel clock is sampled in that domain. A pin selects which pixel-clock edge captures the word. A held word moves into the lane shift registers each time a divide-by-seven counter wraps. A colour-depth pin can turn off the fourth data lane for 18-bit panels. An active-low power-down pin puts the block to sleep and drives every lane low.

Top module: `dlser_top`

## Requirements
- R1: Slot s (0..6, slot 0 sent first) of data lane n carries input bit 7*n + 6 - s of the captured word, so each lane sends its highest bit first and one frame of seven bits fills one pixel period.
- R2: The clock lane repeats the frame 1,1,1,1,0,0,0 over slots 0..6, which gives a 4:3 high/low ratio, and its rising edge marks slot 0 of the data lanes.
- R3: With `edge_rise_i` high, the word captured is the one present when the pixel clock goes from low to high.
- R4: With `edge_rise_i` low, the word captured is the one present when the pixel clock goes from high to low.
- R5: With `color24_i` low, data lane 3 stays at constant 0, and input bits 21..27 do not appear on any output. Lanes 0..2 and the clock lane keep working.
- R6: While `pwrdn_n_i` is low, all four data lanes and the clock lane are 0 from the next bit-clock edge on, and the slot counter is held at slot 0.
- R7: While `rst` is high (synchronous, active high), all lane outputs are 0.
- R8: Consecutive pixel words come out in order, one frame per word, with no word dropped or repeated.
- R9: After `pwrdn_n_i` rises, every output stays 0 for six bit clocks. The clock lane then goes high on the seventh bit clock as slot 0 of the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn_n_i | input | 1 | Active-low power-down; low = sleep, all lanes low |
| edge_rise_i | input | 1 | Capture edge select: 1 = rising, 0 = falling pixel-clock edge |
| color24_i | input | 1 | Colour depth: 1 = 24-bit (four lanes), 0 = 18-bit (lane 3 off) |
| pix_clk_i | input | 1 | Pixel clock, sampled in the bit-clock domain |
| pix_word_i | input | 28 | Pixel word: colour bits plus sync and data-enable bits |
| lane_o | output | 4 | Serial data lanes, one bit each |
| lclk_o | output | 1 | Serial clock lane |

## Verification
The bench deserializes every lane using the clock-lane rising edge for framing. It matches the recovered words in order against a queue of the words it drove.

Random words exercise the general mapping. A walking-one series, together with alternating 0x5555555 and 0xAAAAAAA words, pins each input bit to exactly one lane and slot, so a swapped slot or lane cannot hide.

For edge selection, the word is changed halfway through each pixel period. The rising and falling captures then see different words, so the recovered stream shows which edge was used. An 18-bit run with random upper bits shows whether lane 3 really stays silent. Sleep, reset and wake-up are checked cycle by cycle at the outputs.

// File: rtl/dlser_pkg.sv
package dlser_pkg;

  localparam int unsigned DEF_LANES  = 4;
  localparam int unsigned DEF_SLOTS  = 7;
  localparam int unsigned DEF_WORD_W = DEF_LANES * DEF_SLOTS;
  localparam int unsigned DEF_IDX_W  = $clog2(DEF_WORD_W);

  // Clock lane frame, bit SLOTS-1 is slot 0 (sent first): four high, three low.
  localparam logic [DEF_SLOTS-1:0] DEF_CLK_FRAME = 7'b1111000;

  typedef logic [DEF_LANES*DEF_SLOTS*DEF_IDX_W-1:0] slot_map_t;

  // Entry (lane*SLOTS + slot) holds the word bit index sent in that slot.
  function automatic slot_map_t msb_first_map();
    slot_map_t m;
    m = '0;
    for (int n = 0; n < DEF_LANES; n++) begin
      for (int s = 0; s < DEF_SLOTS; s++) begin
        m[(n*DEF_SLOTS+s)*DEF_IDX_W +: DEF_IDX_W] =
          DEF_IDX_W'(n*DEF_SLOTS + DEF_SLOTS - 1 - s);
      end
    end
    return m;
  endfunction

endpackage

// File: rtl/dlser_edge_cap.sv
module dlser_edge_cap #(
  parameter int unsigned WORD_W = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              pix_clk_i,
  input  logic              rise_sel_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o
);

  logic pix_q;
  logic cap;

  // Previous pixel-clock level keeps tracking in sleep so waking cannot fake an edge.
  always_ff @(posedge clk) begin
    if (rst) pix_q <= 1'b0;
    else     pix_q <= pix_clk_i;
  end

  always_comb begin
    if (rise_sel_i) cap = run &&  pix_clk_i && !pix_q;
    else            cap = run && !pix_clk_i &&  pix_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) word_o <= '0;
    else if (cap)    word_o <= word_i;
  end

  // R3
  cap_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    cap |=> !cap);

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !cap) |=> $stable(word_o));

endmodule

// File: rtl/dlser_div_cnt.sv
module dlser_div_cnt #(
  parameter int unsigned SLOTS = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic wrap_o
);

  localparam int unsigned CNT_W = $clog2(SLOTS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOTS - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)   cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  assign wrap_o = run && (cnt == LAST);

  // R8
  wrap_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);

  // R9
  wake_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/dlser_lane_ser.sv
module dlser_lane_ser #(
  parameter int unsigned SLOTS = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             en,
  input  logic             load,
  input  logic [SLOTS-1:0] frame_i,
  output logic             dout_o
);

  logic [SLOTS-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      sreg   <= '0;
      dout_o <= 1'b0;
    end else if (load) begin
      dout_o <= en & frame_i[SLOTS-1];
      sreg   <= en ? {frame_i[SLOTS-2:0], 1'b0} : '0;
    end else begin
      dout_o <= en & sreg[SLOTS-1];
      sreg   <= {sreg[SLOTS-2:0], 1'b0};
    end
  end

  // R6
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !dout_o);

  // R5
  off_lane_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !dout_o);

endmodule

// File: rtl/dlser_top.sv
module dlser_top #(
  parameter int unsigned LANES      = dlser_pkg::DEF_LANES,
  parameter int unsigned SLOTS      = dlser_pkg::DEF_SLOTS,
  parameter int unsigned SHORT_LANE = 3,
  parameter logic [SLOTS-1:0] CLK_FRAME = dlser_pkg::DEF_CLK_FRAME,
  parameter logic [LANES*SLOTS*$clog2(LANES*SLOTS)-1:0] SLOT_MAP =
    dlser_pkg::msb_first_map()
) (
  input  logic                   clk_bit,
  input  logic                   rst,
  input  logic                   pwrdn_n_i,
  input  logic                   edge_rise_i,
  input  logic                   color24_i,
  input  logic                   pix_clk_i,
  input  logic [LANES*SLOTS-1:0] pix_word_i,
  output logic [LANES-1:0]       lane_o,
  output logic                   lclk_o
);

  localparam int unsigned WORD_W = LANES * SLOTS;
  localparam int unsigned IDX_W  = $clog2(WORD_W);

  logic              run;
  logic              load;
  logic [WORD_W-1:0] held_word;

  assign run = pwrdn_n_i;

  dlser_edge_cap #(.WORD_W(WORD_W)) u_cap (
    .clk        (clk_bit),
    .rst        (rst),
    .run        (run),
    .pix_clk_i  (pix_clk_i),
    .rise_sel_i (edge_rise_i),
    .word_i     (pix_word_i),
    .word_o     (held_word)
  );

  dlser_div_cnt #(.SLOTS(SLOTS)) u_div (
    .clk    (clk_bit),
    .rst    (rst),
    .run    (run),
    .wrap_o (load)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic [SLOTS-1:0] frame;
    logic             en;

    always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
        frame[SLOTS-1-s] = held_word[SLOT_MAP[(n*SLOTS+s)*IDX_W +: IDX_W]];
      end
    end

    if (n == SHORT_LANE) begin : g_short
      assign en = color24_i;
    end else begin : g_full
      assign en = 1'b1;
    end

    dlser_lane_ser #(.SLOTS(SLOTS)) u_ser (
      .clk     (clk_bit),
      .rst     (rst),
      .run     (run),
      .en      (en),
      .load    (load),
      .frame_i (frame),
      .dout_o  (lane_o[n])
    );
  end

  dlser_lane_ser #(.SLOTS(SLOTS)) u_clk_lane (
    .clk     (clk_bit),
    .rst     (rst),
    .run     (run),
    .en      (1'b1),
    .load    (load),
    .frame_i (CLK_FRAME),
    .dout_o  (lclk_o)
  );

  // R2
  clk_slot0_chk: assert property (@(posedge clk_bit) disable iff (rst)
    load |=> lclk_o);

  // R1
  lane0_first_chk: assert property (@(posedge clk_bit) disable iff (rst)
    load |=> (lane_o[0] == $past(g_lane[0].frame[SLOTS-1])));

  // R6
  all_quiet_chk: assert property (@(posedge clk_bit) disable iff (rst)
    !pwrdn_n_i |=> (lane_o == '0 && !lclk_o));

  // R9
  wake_dark_chk: assert property (@(posedge clk_bit) disable iff (rst)
    $rose(pwrdn_n_i) |=> (!lclk_o && lane_o == '0));

  // R7
  always @(posedge clk_bit) begin
    if (rst && $past(rst)) begin
      reset_quiet_chk: assert (lane_o == '0 && !lclk_o);
    end
  end

endmodule

// File: tb/tb_dlser_top.sv
module tb_dlser_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int SLOTS = 7;
  localparam int W     = LANES * SLOTS;
  localparam logic [SLOTS-1:0] CLK_EXP = 7'b1111000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pwrdn_n = 1'b1;
  logic         edge_rise = 1'b1;
  logic         color24 = 1'b1;
  logic         pix_clk = 1'b0;
  logic [W-1:0] pix_word = '0;
  logic [LANES-1:0] lane;
  logic         lclk;

  dlser_top dut (
    .clk_bit     (clk),
    .rst         (rst),
    .pwrdn_n_i   (pwrdn_n),
    .edge_rise_i (edge_rise),
    .color24_i   (color24),
    .pix_clk_i   (pix_clk),
    .pix_word_i  (pix_word),
    .lane_o      (lane),
    .lclk_o      (lclk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int compared   = 0;
  int mismatched = 0;

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Scoreboard state
  logic [W-1:0] expq[$];
  logic [W-1:0] stim_a[$];
  logic [W-1:0] stim_b[$];
  bit           mon_on = 1'b0;
  bit           locked = 1'b0;
  int           skips  = 0;
  int           slot   = -1;
  bit           pat_ok = 1'b1;
  logic         prev_clk = 1'b0;
  logic [W-1:0] rx = '0;
  string        tag = "R1";

  task automatic take_word(logic [W-1:0] w);
    logic [W-1:0] e;
    if (!locked) begin
      if (expq.size() > 0 && w == expq[0]) begin
        locked = 1'b1;
        e = expq.pop_front();
        check(1'b1, tag, w, e);
      end else begin
        skips++;
        if (skips == 8) begin
          check(1'b0, {tag, " no lock on first word (R8)"}, w,
                expq.size() > 0 ? expq[0] : '0);
          locked = 1'b1;
        end
      end
    end else if (expq.size() > 0) begin
      e = expq.pop_front();
      check(w == e, tag, w, e);
    end
  endtask

  // Monitor: frames on clock-lane rising edge, deserializes MSB-first slots (R1, R2)
  always @(negedge clk) begin
    if (!mon_on) begin
      slot = -1;
    end else begin
      if (lclk && !prev_clk) begin
        slot   = 0;
        pat_ok = 1'b1;
        rx     = '0;
      end
      if (slot >= 0) begin
        if (lclk !== CLK_EXP[SLOTS-1-slot]) pat_ok = 1'b0;
        for (int n = 0; n < LANES; n++) rx[n*SLOTS + SLOTS-1-slot] = lane[n];
        slot++;
        if (slot == SLOTS) begin
          slot = -1;
          check(pat_ok, "R2 clock lane frame", W'(pat_ok), W'(1));
          take_word(rx);
        end
      end
    end
    prev_clk = lclk;
  end

  // Driver: word a in the high half of each pixel period, word b in the low half
  task automatic run_phase(string t);
    logic [W-1:0] e;
    expq.delete();
    locked = 1'b0;
    skips  = 0;
    tag    = t;
    @(posedge clk);
    mon_on = 1'b1;
    for (int i = 0; i < stim_a.size(); i++) begin
      e = edge_rise ? stim_a[i] : stim_b[i];
      if (!color24) e[W-1:21] = '0;
      expq.push_back(e);
      for (int p = 0; p < SLOTS; p++) begin
        @(negedge clk);
        pix_clk  = (p < 4);
        pix_word = (p < 4) ? stim_a[i] : stim_b[i];
      end
    end
    repeat (5*SLOTS) @(negedge clk);
    check(expq.size() == 0, {t, " all words delivered (R8)"}, W'(expq.size()), '0);
    @(posedge clk);
    mon_on = 1'b0;
    stim_a.delete();
    stim_b.delete();
  endtask

  task automatic quiet_check(string t, int cycles);
    bit ok;
    logic [W-1:0] seen;
    ok = 1'b1;
    seen = '0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (lane !== '0 || lclk !== 1'b0) begin
        ok = 1'b0;
        seen = W'({lclk, lane});
      end
    end
    check(ok, t, seen, '0);
  endtask

  // R9: six dark bit clocks, clock lane high on the seventh
  task automatic wake_check();
    @(negedge clk);
    pwrdn_n = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      @(negedge clk);
      check(lclk === (k == SLOTS-1), "R9 wake clock lane", W'(lclk), W'(k == SLOTS-1));
      if (k < SLOTS-1) check(lane === '0, "R9 wake data lanes", W'(lane), '0);
    end
  endtask

  task automatic fill_random(int n, bit split);
    logic [W-1:0] a;
    for (int i = 0; i < n; i++) begin
      a = W'($urandom);
      stim_a.push_back(a);
      stim_b.push_back(split ? W'($urandom) : a);
    end
  endtask

  initial begin
    // R7: reset alone forces outputs low
    repeat (2) @(negedge clk);
    quiet_check("R7 reset state", 4);
    @(negedge clk);
    rst = 1'b0;
    pwrdn_n = 1'b0;
    // R6: sleep is quiet even with pixel activity
    for (int k = 0; k < 3; k++) begin
      pix_word = W'($urandom);
      pix_clk  = ~pix_clk;
      @(negedge clk);
    end
    pix_clk = 1'b0;
    quiet_check("R6 default sleep", 8);
    wake_check();

    // R1, R8: random words, capture on rising edge
    fill_random(16, 1'b0);
    run_phase("R1 random words");

    // R3: halves differ, rising edge must pick the first half
    fill_random(12, 1'b1);
    run_phase("R3 rising capture");

    // R4: falling edge must pick the second half
    edge_rise = 1'b0;
    fill_random(12, 1'b1);
    run_phase("R4 falling capture");
    edge_rise = 1'b1;

    // R5: 18-bit mode, upper bits random but lane 3 silent
    color24 = 1'b0;
    fill_random(12, 1'b0);
    run_phase("R5 18-bit mode");
    color24 = 1'b1;

    // R6: power down mid-stream, then wake again (R9)
    @(negedge clk);
    pwrdn_n = 1'b0;
    quiet_check("R6 power down", 12);
    wake_check();

    // R1: walking one and alternating patterns pin each bit to its slot
    for (int i = 0; i < W; i++) begin
      stim_a.push_back(W'(1) << i);
      stim_b.push_back(W'(1) << i);
    end
    stim_a.push_back(28'h5555555); stim_b.push_back(28'h5555555);
    stim_a.push_back(28'hAAAAAAA); stim_b.push_back(28'hAAAAAAA);
    stim_a.push_back(28'hFFFFFFF); stim_b.push_back(28'hFFFFFFF);
    run_phase("R1 walking one");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", '0, W'(1));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule